// File: doc/BRIEF.md
# Stream-to-Memory Burst Write Engine

This block takes write commands from a command stream and payload words from a data stream, and writes the payload into memory through the write side of an AXI4 master: address (AW), data (W) and response (B). Each command names a start address, a byte count and an addressing mode. The engine cuts the transfer into legal bursts without outside help. It never lets an incrementing burst run past a 4 KB page, and it never issues more than 16 beats in one burst. After the last response of a command has come back, it reports one status word on a separate status stream.

A four-entry command queue sits in front of the engine, so a producer can post several transfers in a row and the next one starts as soon as the current one finishes. Fixed-address mode sends every beat to the same address, which lets a stream be poured into a single register. Payload addresses are word aligned. Only the last beat of a command may carry a partial keep, and the engine passes the keep through unchanged as the write strobe.

Top module: `s2m_burst_writer`

## Requirements
- R1: A command word is 53 bits: bits [31:0] start address, bits [47:32] byte count (nonzero), bit 48 mode (1 incrementing, 0 fixed), bits [52:49] tag. Commands are carried out in the order they are accepted.
- R2: A command of N bytes moves ceil(N/4) beats. WDATA is the stream word and WSTRB is the stream keep: 4'hF on every beat except the last, whose keep is (1<<(N mod 4))-1 when N mod 4 is nonzero.
- R3: AWLEN never exceeds 15. A burst is as long as the smaller of the beats left and 16, further limited as R4 states.
- R4: In incrementing mode no burst crosses a 4 KB boundary: a burst that would reach past the page ends at it, and the next burst starts at the page boundary. Successive bursts continue at the address where the previous one ended.
- R5: Incrementing commands drive AWBURST=2'b01. Fixed commands drive AWBURST=2'b00, and every burst of the command uses the command's start address.
- R6: WLAST is high on the final beat of each burst and on no other beat. No W beat is presented between the last beat of a burst and the acceptance of the next address.
- R7: The command queue holds 4 commands. While it is full, the command TREADY is low.
- R8: Exactly one status word is returned per command, in command order, and only after every B response of that command has been taken. Status bits: [3:0] tag, [4] okay, [5] error, [7:6] zero.
- R9: The error bit is set when any B response of the command is SLVERR (2'b10) or DECERR (2'b11). The okay bit is its inverse.
- R10: After reset, AWVALID, WVALID and the status TVALID are low and the command TREADY is high.
- R11: Once AWVALID is raised, it and AWADDR and AWLEN hold steady until AWREADY accepts the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_cmd_tvalid | input | 1 | Command stream valid |
| s_cmd_tready | output | 1 | Command stream ready, low while the queue is full |
| s_cmd_tdata | input | 53 | Command word (address, byte count, mode, tag) |
| s_dat_tvalid | input | 1 | Payload stream valid |
| s_dat_tready | output | 1 | Payload stream ready |
| s_dat_tdata | input | 32 | Payload word |
| s_dat_tkeep | input | 4 | Payload byte keep |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Burst start address |
| m_awlen | output | 8 | Beats in burst minus one |
| m_awsize | output | 3 | Beat size code (4 bytes) |
| m_awburst | output | 2 | Burst type, fixed or incrementing |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes |
| m_wlast | output | 1 | Final beat of the burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_sts_tvalid | output | 1 | Status stream valid |
| m_sts_tready | input | 1 | Status stream ready |
| m_sts_tdata | output | 8 | Status word |

## Verification
The hardest state to reach from the ports is a full queue behind a stalled engine, together with bursts that start a few words short of a page edge while the W, B and status handshakes are throttled on different periods. The bench sweeps both modes over start offsets just below a 4 KB edge and byte counts around the 16-beat limit, with keeps left partial, and computes the burst list and strobes arithmetically for each command. It then holds AWREADY low, so that one command sits in the engine and four fill the queue, and probes the command ready before it releases the address channel. SLVERR and DECERR are injected on a fixed pattern of burst numbers, so some commands see an error only on a middle burst.

// File: rtl/s2m_pkg.sv
package s2m_pkg;

    localparam int ADDR_W = 32;
    localparam int BTT_W  = 16;
    localparam int TAG_W  = 4;
    localparam int STS_W  = 8;

    localparam logic [1:0] BURST_FIXED = 2'b00;
    localparam logic [1:0] BURST_INCR  = 2'b01;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic              incr;
        logic [BTT_W-1:0]  btt;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_WAITB,
        ST_STAT
    } eng_state_e;

endpackage

// File: rtl/s2m_cmd_fifo.sv
module s2m_cmd_fifo #(
    parameter int WIDTH = 53,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            count;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic  in_fire, out_fire;

    always_comb begin
        fifo_d   = fifo_q;
        in_fire  = in_valid && (fifo_q.count != CNT_W'(DEPTH));
        out_fire = out_ready && (fifo_q.count != '0);
        if (in_fire) begin
            fifo_d.mem[fifo_q.wr] = in_data;
            fifo_d.wr = (fifo_q.wr == PTR_W'(DEPTH - 1)) ? '0 : fifo_q.wr + 1'b1;
        end
        if (out_fire) begin
            fifo_d.rd = (fifo_q.rd == PTR_W'(DEPTH - 1)) ? '0 : fifo_q.rd + 1'b1;
        end
        if (in_fire && !out_fire) begin
            fifo_d.count = fifo_q.count + 1'b1;
        end else if (!in_fire && out_fire) begin
            fifo_d.count = fifo_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    assign in_ready  = (fifo_q.count != CNT_W'(DEPTH));
    assign out_valid = (fifo_q.count != '0);
    assign out_data  = fifo_q.mem[fifo_q.rd];

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !(out_valid && out_ready))
        |=> (fifo_q.count == $past(fifo_q.count) + 1'b1));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (fifo_q.count < CNT_W'(DEPTH)));

endmodule

// File: rtl/s2m_burst_calc.sv
module s2m_burst_calc #(
    parameter int PAGE_BYTES = 4096,
    parameter int BEAT_BYTES = 4,
    parameter int MAX_BEATS  = 16,
    parameter int LEFT_W     = 16,
    parameter int PAGE_W     = $clog2(PAGE_BYTES),
    parameter int LEN_W      = $clog2(MAX_BEATS + 1)
) (
    input  logic [PAGE_W-1:0] page_off,
    input  logic [LEFT_W-1:0] beats_left,
    input  logic              incr,
    output logic [LEN_W-1:0]  len
);

    localparam int SHIFT = $clog2(BEAT_BYTES);

    logic [31:0] room_beats;
    logic [31:0] cap;
    logic [31:0] left_w;

    always_comb begin
        room_beats = (32'(PAGE_BYTES) - 32'(page_off)) >> SHIFT;
        left_w     = 32'(beats_left);
        cap        = 32'(MAX_BEATS);
        if (incr && (room_beats < cap)) begin
            cap = room_beats;
        end
        len = (left_w < cap) ? LEN_W'(left_w) : LEN_W'(cap);
    end

endmodule

// File: rtl/s2m_engine.sv
module s2m_engine
    import s2m_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int MAX_BEATS  = 16,
    parameter int PAGE_BYTES = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                q_valid,
    input  cmd_t                q_data,
    output logic                q_ready,
    input  logic                s_tvalid,
    output logic                s_tready,
    input  logic [DATA_W-1:0]   s_tdata,
    input  logic [DATA_W/8-1:0] s_tkeep,
    output logic                awvalid,
    input  logic                awready,
    output logic [ADDR_W-1:0]   awaddr,
    output logic [7:0]          awlen,
    output logic [2:0]          awsize,
    output logic [1:0]          awburst,
    output logic                wvalid,
    input  logic                wready,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic                wlast,
    input  logic                bvalid,
    output logic                bready,
    input  logic [1:0]          bresp,
    output logic                sts_valid,
    input  logic                sts_ready,
    output logic [STS_W-1:0]    sts_data
);

    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int SHIFT      = $clog2(BEAT_BYTES);
    localparam int PAGE_W     = $clog2(PAGE_BYTES);
    localparam int LEN_W      = $clog2(MAX_BEATS + 1);

    typedef struct packed {
        eng_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [BTT_W-1:0]  left;
        logic              incr;
        logic [TAG_W-1:0]  tag;
        logic [LEN_W-1:0]  burst_rem;
        logic [BTT_W-1:0]  outst;
        logic              err;
    } eng_t;

    eng_t             eng_d, eng_q;
    logic [LEN_W-1:0] len;
    logic [BTT_W-1:0] cmd_beats;
    logic             aw_fire, w_fire, b_fire;

    s2m_burst_calc #(
        .PAGE_BYTES (PAGE_BYTES),
        .BEAT_BYTES (BEAT_BYTES),
        .MAX_BEATS  (MAX_BEATS),
        .LEFT_W     (BTT_W),
        .PAGE_W     (PAGE_W),
        .LEN_W      (LEN_W)
    ) u_calc (
        .page_off   (eng_q.addr[PAGE_W-1:0]),
        .beats_left (eng_q.left),
        .incr       (eng_q.incr),
        .len        (len)
    );

    assign cmd_beats = BTT_W'(({1'b0, q_data.btt} + (BTT_W+1)'(BEAT_BYTES - 1)) >> SHIFT);

    assign q_ready   = (eng_q.st == ST_IDLE);
    assign awvalid   = (eng_q.st == ST_ADDR);
    assign awaddr    = eng_q.addr;
    assign awlen     = 8'(len - 1'b1);
    assign awsize    = 3'(SHIFT);
    assign awburst   = eng_q.incr ? BURST_INCR : BURST_FIXED;
    assign wvalid    = (eng_q.st == ST_DATA) && s_tvalid;
    assign s_tready  = (eng_q.st == ST_DATA) && wready;
    assign wdata     = s_tdata;
    assign wstrb     = s_tkeep;
    assign wlast     = (eng_q.burst_rem == LEN_W'(1));
    assign bready    = (eng_q.st != ST_IDLE);
    assign sts_valid = (eng_q.st == ST_STAT);
    assign sts_data  = {2'b00, eng_q.err, !eng_q.err, eng_q.tag};

    assign aw_fire = awvalid && awready;
    assign w_fire  = wvalid && wready;
    assign b_fire  = bvalid && bready;

    always_comb begin
        eng_d = eng_q;
        if (aw_fire && !b_fire) begin
            eng_d.outst = eng_q.outst + 1'b1;
        end else if (!aw_fire && b_fire) begin
            eng_d.outst = eng_q.outst - 1'b1;
        end
        if (b_fire && bresp[1]) begin
            eng_d.err = 1'b1;
        end
        unique case (eng_q.st)
            ST_IDLE: begin
                if (q_valid) begin
                    eng_d.addr  = q_data.addr;
                    eng_d.left  = cmd_beats;
                    eng_d.incr  = q_data.incr;
                    eng_d.tag   = q_data.tag;
                    eng_d.err   = 1'b0;
                    eng_d.st    = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (aw_fire) begin
                    eng_d.burst_rem = len;
                    eng_d.left      = eng_q.left - BTT_W'(len);
                    if (eng_q.incr) begin
                        eng_d.addr = eng_q.addr + (ADDR_W'(len) << SHIFT);
                    end
                    eng_d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                if (w_fire) begin
                    eng_d.burst_rem = eng_q.burst_rem - 1'b1;
                    if (eng_q.burst_rem == LEN_W'(1)) begin
                        eng_d.st = (eng_q.left == '0) ? ST_WAITB : ST_ADDR;
                    end
                end
            end
            ST_WAITB: begin
                if (eng_q.outst == '0) begin
                    eng_d.st = ST_STAT;
                end
            end
            ST_STAT: begin
                if (sts_ready) begin
                    eng_d.st = ST_IDLE;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    // R3
    awlen_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (awlen <= 8'(MAX_BEATS - 1)));

    // R4
    no_cross_4k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && (awburst == BURST_INCR))
        |-> ((32'(awaddr[PAGE_W-1:0]) + ((32'(awlen) + 1) << SHIFT)) <= 32'(PAGE_BYTES)));

    // R11
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));

    // R6
    wlast_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && wready && wlast) |=> !wvalid);

    // R8
    sts_after_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |-> (eng_q.outst == '0));

endmodule

// File: rtl/s2m_burst_writer.sv
module s2m_burst_writer
    import s2m_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int QDEPTH     = 4,
    parameter int MAX_BEATS  = 16,
    parameter int PAGE_BYTES = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_cmd_tvalid,
    output logic                s_cmd_tready,
    input  logic [CMD_W-1:0]    s_cmd_tdata,
    input  logic                s_dat_tvalid,
    output logic                s_dat_tready,
    input  logic [DATA_W-1:0]   s_dat_tdata,
    input  logic [DATA_W/8-1:0] s_dat_tkeep,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic                m_wvalid,
    input  logic                m_wready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    input  logic                m_bvalid,
    output logic                m_bready,
    input  logic [1:0]          m_bresp,
    output logic                m_sts_tvalid,
    input  logic                m_sts_tready,
    output logic [STS_W-1:0]    m_sts_tdata
);

    logic             q_valid, q_ready;
    logic [CMD_W-1:0] q_raw;

    s2m_cmd_fifo #(
        .WIDTH (CMD_W),
        .DEPTH (QDEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_cmd_tvalid),
        .in_ready  (s_cmd_tready),
        .in_data   (s_cmd_tdata),
        .out_valid (q_valid),
        .out_ready (q_ready),
        .out_data  (q_raw)
    );

    s2m_engine #(
        .DATA_W     (DATA_W),
        .MAX_BEATS  (MAX_BEATS),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_valid   (q_valid),
        .q_data    (cmd_t'(q_raw)),
        .q_ready   (q_ready),
        .s_tvalid  (s_dat_tvalid),
        .s_tready  (s_dat_tready),
        .s_tdata   (s_dat_tdata),
        .s_tkeep   (s_dat_tkeep),
        .awvalid   (m_awvalid),
        .awready   (m_awready),
        .awaddr    (m_awaddr),
        .awlen     (m_awlen),
        .awsize    (m_awsize),
        .awburst   (m_awburst),
        .wvalid    (m_wvalid),
        .wready    (m_wready),
        .wdata     (m_wdata),
        .wstrb     (m_wstrb),
        .wlast     (m_wlast),
        .bvalid    (m_bvalid),
        .bready    (m_bready),
        .bresp     (m_bresp),
        .sts_valid (m_sts_tvalid),
        .sts_ready (m_sts_tready),
        .sts_data  (m_sts_tdata)
    );

endmodule

// File: tb/s2m_burst_writer_tb.sv
module s2m_burst_writer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_cmd_tvalid = 1'b0;
    logic        s_cmd_tready;
    logic [52:0] s_cmd_tdata = '0;
    logic        s_dat_tvalid = 1'b0;
    logic        s_dat_tready;
    logic [31:0] s_dat_tdata = '0;
    logic [3:0]  s_dat_tkeep = '0;
    logic        m_awvalid;
    logic        m_awready = 1'b0;
    logic [31:0] m_awaddr;
    logic [7:0]  m_awlen;
    logic [2:0]  m_awsize;
    logic [1:0]  m_awburst;
    logic        m_wvalid;
    logic        m_wready = 1'b0;
    logic [31:0] m_wdata;
    logic [3:0]  m_wstrb;
    logic        m_wlast;
    logic        m_bvalid = 1'b0;
    logic        m_bready;
    logic [1:0]  m_bresp = 2'b00;
    logic        m_sts_tvalid;
    logic        m_sts_tready = 1'b0;
    logic [7:0]  m_sts_tdata;

    always #10 clk = ~clk;

    s2m_burst_writer u_dut (
        .clk (clk), .rst_n (rst_n),
        .s_cmd_tvalid (s_cmd_tvalid), .s_cmd_tready (s_cmd_tready), .s_cmd_tdata (s_cmd_tdata),
        .s_dat_tvalid (s_dat_tvalid), .s_dat_tready (s_dat_tready),
        .s_dat_tdata (s_dat_tdata), .s_dat_tkeep (s_dat_tkeep),
        .m_awvalid (m_awvalid), .m_awready (m_awready), .m_awaddr (m_awaddr),
        .m_awlen (m_awlen), .m_awsize (m_awsize), .m_awburst (m_awburst),
        .m_wvalid (m_wvalid), .m_wready (m_wready), .m_wdata (m_wdata),
        .m_wstrb (m_wstrb), .m_wlast (m_wlast),
        .m_bvalid (m_bvalid), .m_bready (m_bready), .m_bresp (m_bresp),
        .m_sts_tvalid (m_sts_tvalid), .m_sts_tready (m_sts_tready), .m_sts_tdata (m_sts_tdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int gb = 0;
    int cmd_no = 0;
    bit aw_block = 1'b0;

    longint exp_aw_addr[$];
    int     exp_aw_len[$];
    int     exp_aw_bt[$];
    int     exp_last[$];
    int     exp_keep[$];
    int     exp_sts[$];
    int     aw_idx = 0;
    int     w_idx = 0;
    int     b_pend = 0;
    int     b_cnt = 0;
    int     sts_idx = 0;
    bit     prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [7:0]  prev_len = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] pat(input int i);
        return 32'(i) * 32'h9E3779B1 ^ 32'h5A00_C3C3;
    endfunction

    function automatic logic [1:0] resp_for(input int n);
        if ((n % 7) == 3) return 2'b10;
        if ((n % 11) == 5) return 2'b11;
        return 2'b00;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected bursts, beats and status computed from R2..R5, R8, R9
    task automatic plan_cmd(input longint addr, input int btt, input int incr, input int tag);
        int beats = (btt + 3) / 4;
        int total = beats;
        int bi = 0;
        longint a = addr;
        bit err = 1'b0;
        while (beats > 0) begin
            int n = (beats > 16) ? 16 : beats;
            if (incr != 0) begin
                int room = int'((4096 - (a % 4096)) / 4);
                if (room < n) n = room;
            end
            exp_aw_addr.push_back(a);
            exp_aw_len.push_back(n - 1);
            exp_aw_bt.push_back(incr);
            for (int k = 0; k < n; k++) begin
                int kp = 15;
                if ((bi == total - 1) && ((btt % 4) != 0)) kp = (1 << (btt % 4)) - 1;
                exp_last.push_back((k == n - 1) ? 1 : 0);
                exp_keep.push_back(kp);
                bi++;
            end
            if (resp_for(gb)[1]) err = 1'b1;
            gb++;
            beats -= n;
            if (incr != 0) a += 4 * n;
        end
        exp_sts.push_back({2'b00, err, !err, 4'(tag)});
    endtask

    task automatic send_cmd(input longint addr, input int btt, input int incr);
        int tag = cmd_no % 16;
        cmd_no++;
        plan_cmd(addr, btt, incr, tag);
        @(negedge clk);
        s_cmd_tvalid = 1'b1;
        s_cmd_tdata  = {4'(tag), 1'(incr), 16'(btt), 32'(addr)};
        #1;
        while (!s_cmd_tready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        s_cmd_tvalid = 1'b0;
    endtask

    // memory-side responder and stream source; drives at the falling edge, samples 1 ns later
    initial begin
        forever begin
            @(negedge clk);
            m_awready    = !aw_block && ((cyc % 3) != 1);
            m_wready     = ((cyc % 7) != 4);
            m_bvalid     = (b_pend > 0);
            m_bresp      = resp_for(b_cnt);
            m_sts_tready = ((cyc % 4) != 3);
            s_dat_tvalid = (w_idx < exp_keep.size()) && ((cyc % 5) != 2);
            s_dat_tdata  = pat(w_idx);
            s_dat_tkeep  = (w_idx < exp_keep.size()) ? 4'(exp_keep[w_idx]) : 4'h0;
            #1;
            if (rst_n) begin
                if (prev_wait) begin
                    // R11
                    chk(m_awvalid && (m_awaddr == prev_addr) && (m_awlen == prev_len),
                        "R11", "aw held", {m_awaddr, m_awlen}, {prev_addr, prev_len});
                end
                prev_wait = m_awvalid && !m_awready;
                prev_addr = m_awaddr;
                prev_len  = m_awlen;
                if (m_awvalid && m_awready) begin
                    if (aw_idx < exp_aw_addr.size()) begin
                        chk(m_awaddr == 32'(exp_aw_addr[aw_idx]), "R4", "awaddr", m_awaddr, exp_aw_addr[aw_idx]);
                        chk(m_awlen == 8'(exp_aw_len[aw_idx]), "R3", "awlen", m_awlen, exp_aw_len[aw_idx]);
                        chk(m_awburst == 2'(exp_aw_bt[aw_idx]), "R5", "awburst", m_awburst, exp_aw_bt[aw_idx]);
                        chk(m_awsize == 3'd2, "R2", "awsize", m_awsize, 2);
                    end else begin
                        chk(1'b0, "R3", "extra burst", m_awaddr, 0);
                    end
                    aw_idx++;
                end
                if (m_wvalid && m_wready) begin
                    if (w_idx < exp_keep.size()) begin
                        chk(m_wdata == pat(w_idx), "R2", "wdata", m_wdata, pat(w_idx));
                        chk(m_wstrb == 4'(exp_keep[w_idx]), "R2", "wstrb", m_wstrb, exp_keep[w_idx]);
                        chk(m_wlast == 1'(exp_last[w_idx]), "R6", "wlast", m_wlast, exp_last[w_idx]);
                    end else begin
                        chk(1'b0, "R2", "extra beat", m_wdata, 0);
                    end
                    if (m_wlast) b_pend++;
                    w_idx++;
                end
                if (m_bvalid && m_bready) begin
                    b_pend--;
                    b_cnt++;
                end
                if (m_sts_tvalid && m_sts_tready) begin
                    if (sts_idx < exp_sts.size()) begin
                        chk(m_sts_tdata[3:0] == 4'(exp_sts[sts_idx]), "R8", "status tag", m_sts_tdata, exp_sts[sts_idx]);
                        chk(m_sts_tdata[5:4] == 2'(exp_sts[sts_idx] >> 4), "R9", "status flags", m_sts_tdata, exp_sts[sts_idx]);
                        chk(b_pend == 0, "R8", "status before B", b_pend, 0);
                    end else begin
                        chk(1'b0, "R8", "extra status", m_sts_tdata, 0);
                    end
                    sts_idx++;
                end
            end
        end
    end

    task automatic wait_drain();
        while ((sts_idx < exp_sts.size()) || (b_pend != 0)) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic run_all();
        int offs[5] = '{0, 4032, 4088, 4092, 2000};
        int btts[7] = '{1, 4, 7, 64, 65, 70, 131};
        repeat (5) @(posedge clk);
        @(negedge clk);
        #2;
        // R10
        chk(!m_awvalid && !m_wvalid && !m_sts_tvalid, "R10", "valids in reset",
            {m_awvalid, m_wvalid, m_sts_tvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(!m_awvalid && !m_wvalid && !m_sts_tvalid && s_cmd_tready, "R10", "after reset",
            {m_awvalid, m_wvalid, m_sts_tvalid, s_cmd_tready}, 1);

        // R1 R3 R4 R5 sweep over mode, page offset and byte count
        for (int t = 0; t < 2; t++) begin
            for (int o = 0; o < 5; o++) begin
                for (int b = 0; b < 7; b++) begin
                    send_cmd(longint'(32'h0002_0000 + 32'(o) * 32'h0001_0000 + 32'(offs[o])), btts[b], t);
                end
            end
        end
        wait_drain();
        chk(aw_idx == exp_aw_addr.size(), "R3", "burst count", aw_idx, exp_aw_addr.size());
        chk(sts_idx == exp_sts.size(), "R8", "status count", sts_idx, exp_sts.size());

        // R7 queue fills behind a stalled address channel
        aw_block = 1'b1;
        for (int i = 0; i < 5; i++) send_cmd(longint'(32'h0040_0FF0 + 32'(i) * 32'h100), 40 + i, i % 2);
        @(negedge clk);
        s_cmd_tvalid = 1'b1;
        s_cmd_tdata  = {4'hF, 1'b1, 16'd8, 32'h0050_0000};
        for (int i = 0; i < 6; i++) begin
            #1;
            chk(!s_cmd_tready, "R7", "ready while full", s_cmd_tready, 0);
            @(negedge clk);
        end
        s_cmd_tvalid = 1'b0;
        aw_block = 1'b0;
        send_cmd(longint'(32'h0050_0FFC), 12, 1);
        wait_drain();
        chk(sts_idx == exp_sts.size(), "R7", "all queued done", sts_idx, exp_sts.size());
        chk(w_idx == exp_keep.size(), "R2", "beat count", w_idx, exp_keep.size());
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", sts_idx, exp_sts.size());
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule